// File: doc/BRIEF.md
# Arbitrating Interrupt Capture Register

This block sits between the interrupt sources of a multi-channel serial controller and the host. Each source bids for service with a priority value, and the FIFO sources also report how many bytes are waiting to be moved. A combinational arbiter picks the highest bid all the time and compares it with a programmable threshold. The result drives a registered interrupt request line. It is also the value that a capture event freezes into the current-interrupt word.

A capture event is either a host write to the current-interrupt address or a falling edge on the asynchronous interrupt-acknowledge input. In a polling loop the host writes that address and then reads it. A zero word means nothing needs service. A non-zero word gives the source type, the channel and the byte count. The word stays frozen until the next capture. A separate global receive-data address returns the byte from whichever receive FIFO currently bids highest, and pulses a one-hot pop strobe toward that FIFO.

Top module: `irq_capture_arb`

## Requirements
- R1: After reset the current-interrupt word reads 0, the threshold reads 0 and irq is low.
- R2: A write of any data to address 0 loads the current-interrupt word from the live arbitration result at that clock edge. The new word is readable from the following cycle.
- R3: If no source bid is strictly greater than the threshold at the capture edge, the word loads 0.
- R4: A bid equal to the threshold does not win. Among equal highest bids the lowest source index wins.
- R5: Between capture events the word does not change, whatever happens to bids, counts or the threshold.
- R6: A falling edge of iack_n captures exactly like an address-0 write, on the third rising clock edge after the edge is applied. Holding iack_n low or raising it causes no further capture.
- R7: Sources 0 to NUM_FIFO-1 place their byte count in the count field. Every other source places 0 there.
- R8: The word layout is bits [12:9] type = winning index + 1, bit [8] channel = index modulo NUM_CHAN, bits [7:0] count. It is zero-extended to 16 bits on read.
- R9: irq is registered. In each cycle it equals whether some bid exceeded the threshold in the previous cycle, independent of the captured word.
- R10: A read of address 2 returns the rx_data byte of the receive source (indices 0 to NUM_RX-1) with the highest non-zero bid, lowest index on ties. rx_pop pulses one-hot for that source in the same cycle. If all receive bids are 0 the read returns 0 and no pop is made.
- R11: Address 1 holds the threshold. It is written from bus_wdata and reads back in the cycle after the write.
- R12: With the threshold at 0, any single non-zero bid yields a non-zero word on the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iack_n | input | 1 | Asynchronous interrupt acknowledge, falling edge captures |
| src_bid | input | NUM_SRC*BID_W | Bid of each source, source i at bits [i*BID_W +: BID_W] |
| fifo_cnt | input | NUM_FIFO*CNT_W | Byte count of each FIFO source |
| rx_data | input | NUM_RX*DATA_W | Head byte of each receive FIFO |
| bus_addr | input | 2 | Register address: 0 word, 1 threshold, 2 global receive data, 3 reads 0 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, only affects pops at address 2 |
| bus_wdata | input | BID_W | Write data |
| bus_rdata | output | BUS_W | Combinational read data for bus_addr |
| rx_pop | output | NUM_RX | One-hot pop strobe toward the winning receive FIFO |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench uses the default build: eleven sources, four of them FIFOs with the first two receiving, two channels and 8-bit bids. With these values the type field reaches its top value of 11, and both channel values appear. Non-FIFO winners with a zero count field can be told apart from FIFO winners, and the receive selector has a real two-way choice including ties. The 8-bit threshold lets bids equal to and just above it be placed, so the strict comparison is exercised.

// File: rtl/ica_pkg.sv
package ica_pkg;

  typedef enum logic [1:0] {
    A_CIR = 2'd0,
    A_THR = 2'd1,
    A_GRX = 2'd2,
    A_RSV = 2'd3
  } ica_addr_e;

  localparam int ICA_ADDR_W = 2;

endpackage

// File: rtl/ica_rst_sync.sv
module ica_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/ica_ack_edge.sv
module ica_ack_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_async,
  output logic fall_pulse
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   last_q;
  logic                   last_d;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], ack_n_async};
    last_d = synced;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  // previous synchronized level high, current low
  assign fall_pulse = last_q & ~synced;

endmodule

// File: rtl/ica_bid_max.sv
module ica_bid_max #(
  parameter int N     = 11,
  parameter int BID_W = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*BID_W-1:0] bids,
  input  logic [BID_W-1:0]   thr_i,
  output logic               win_vld,
  output logic [IDX_W-1:0]   win_idx
);

  logic [BID_W-1:0] best;

  // strict greater-than keeps the earliest index on ties
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    best    = thr_i;
    for (int i = 0; i < N; i++) begin
      if (bids[i*BID_W +: BID_W] > best) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(i);
        best    = bids[i*BID_W +: BID_W];
      end
    end
  end

endmodule

// File: rtl/ica_cir_reg.sv
module ica_cir_reg #(
  parameter int NUM_SRC  = 11,
  parameter int NUM_FIFO = 4,
  parameter int NUM_CHAN = 2,
  parameter int CNT_W    = 8,
  parameter int TYPE_W   = 4,
  parameter int CHAN_W   = 1,
  parameter int IDX_W    = 4,
  parameter int CIR_W    = TYPE_W + CHAN_W + CNT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap,
  input  logic                      win_vld,
  input  logic [IDX_W-1:0]          win_idx,
  input  logic [NUM_FIFO*CNT_W-1:0] fifo_cnt,
  output logic [CIR_W-1:0]          cir_q
);

  logic [CIR_W-1:0] cand [NUM_SRC];
  logic [CIR_W-1:0] sel;
  logic [CIR_W-1:0] cir_d;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cand
    localparam int TYP = g + 1;
    localparam int CH  = g % NUM_CHAN;
    if (g < NUM_FIFO) begin : g_fifo
      assign cand[g] = {TYPE_W'(TYP), CHAN_W'(CH), fifo_cnt[g*CNT_W +: CNT_W]};
    end else begin : g_plain
      assign cand[g] = {TYPE_W'(TYP), CHAN_W'(CH), {CNT_W{1'b0}}};
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (win_idx == IDX_W'(i)) begin
        sel = cand[i];
      end
    end
  end

  always_comb begin
    cir_d = cir_q;
    if (cap) begin
      cir_d = win_vld ? sel : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cir_q <= '0;
    end else begin
      cir_q <= cir_d;
    end
  end

endmodule

// File: rtl/irq_capture_arb.sv
module irq_capture_arb
  import ica_pkg::*;
#(
  parameter int NUM_SRC  = 11,
  parameter int NUM_FIFO = 4,
  parameter int NUM_RX   = 2,
  parameter int NUM_CHAN = 2,
  parameter int BID_W    = 8,
  parameter int CNT_W    = 8,
  parameter int DATA_W   = 8,
  parameter int BUS_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iack_n,
  input  logic [NUM_SRC*BID_W-1:0]  src_bid,
  input  logic [NUM_FIFO*CNT_W-1:0] fifo_cnt,
  input  logic [NUM_RX*DATA_W-1:0]  rx_data,
  input  logic [ICA_ADDR_W-1:0]     bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [BID_W-1:0]          bus_wdata,
  output logic [BUS_W-1:0]          bus_rdata,
  output logic [NUM_RX-1:0]         rx_pop,
  output logic                      irq
);

  localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int RX_IDX_W = (NUM_RX > 1) ? $clog2(NUM_RX) : 1;
  localparam int TYPE_W   = $clog2(NUM_SRC + 1);
  localparam int CHAN_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
  localparam int CIR_W    = TYPE_W + CHAN_W + CNT_W;

  logic                rst_n_s;
  logic                ack_fall;
  logic                wr_cir;
  logic                wr_thr;
  logic                rd_grx;
  logic                cap;
  logic [BID_W-1:0]    thr_q;
  logic [BID_W-1:0]    thr_d;
  logic                irq_q;
  logic                irq_d;
  logic                win_vld;
  logic [IDX_W-1:0]    win_idx;
  logic                rx_vld;
  logic [RX_IDX_W-1:0] rx_idx;
  logic [DATA_W-1:0]   rx_sel;
  logic [CIR_W-1:0]    cir_q;

  ica_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_s)
  );

  ica_ack_edge #(.SYNC_STAGES(2)) u_ack (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .ack_n_async (iack_n),
    .fall_pulse  (ack_fall)
  );

  ica_bid_max #(.N(NUM_SRC), .BID_W(BID_W), .IDX_W(IDX_W)) u_arb (
    .bids    (src_bid),
    .thr_i   (thr_q),
    .win_vld (win_vld),
    .win_idx (win_idx)
  );

  ica_bid_max #(.N(NUM_RX), .BID_W(BID_W), .IDX_W(RX_IDX_W)) u_rx_arb (
    .bids    (src_bid[NUM_RX*BID_W-1:0]),
    .thr_i   ({BID_W{1'b0}}),
    .win_vld (rx_vld),
    .win_idx (rx_idx)
  );

  assign wr_cir = bus_wr & (bus_addr == A_CIR);
  assign wr_thr = bus_wr & (bus_addr == A_THR);
  assign rd_grx = bus_rd & (bus_addr == A_GRX);
  assign cap    = wr_cir | ack_fall;

  ica_cir_reg #(
    .NUM_SRC  (NUM_SRC),
    .NUM_FIFO (NUM_FIFO),
    .NUM_CHAN (NUM_CHAN),
    .CNT_W    (CNT_W),
    .TYPE_W   (TYPE_W),
    .CHAN_W   (CHAN_W),
    .IDX_W    (IDX_W),
    .CIR_W    (CIR_W)
  ) u_cir (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cap      (cap),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .fifo_cnt (fifo_cnt),
    .cir_q    (cir_q)
  );

  // threshold and request register next state
  always_comb begin
    thr_d = thr_q;
    if (wr_thr) begin
      thr_d = bus_wdata;
    end
    irq_d = win_vld;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      thr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      thr_q <= thr_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  always_comb begin
    rx_sel = '0;
    for (int i = 0; i < NUM_RX; i++) begin
      if (rx_vld && (rx_idx == RX_IDX_W'(i))) begin
        rx_sel = rx_data[i*DATA_W +: DATA_W];
      end
    end
  end

  for (genvar g = 0; g < NUM_RX; g++) begin : g_pop
    assign rx_pop[g] = rd_grx & rx_vld & (rx_idx == RX_IDX_W'(g));
  end

  always_comb begin
    case (bus_addr)
      A_CIR:   bus_rdata = BUS_W'(cir_q);
      A_THR:   bus_rdata = BUS_W'(thr_q);
      A_GRX:   bus_rdata = BUS_W'(rx_sel);
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ica_checker.sv
module ica_checker #(
  parameter int NUM_SRC = 11,
  parameter int NUM_RX  = 2,
  parameter int BID_W   = 8,
  parameter int TYPE_W  = 4,
  parameter int CIR_W   = 13
) (
  input logic                     clk,
  input logic                     rst_n_s,
  input logic                     bus_wr,
  input logic [1:0]               bus_addr,
  input logic                     ack_fall,
  input logic                     cap,
  input logic                     win_vld,
  input logic [CIR_W-1:0]         cir_q,
  input logic [NUM_SRC*BID_W-1:0] src_bid,
  input logic [BID_W-1:0]         thr_q,
  input logic                     irq,
  input logic [NUM_RX-1:0]        rx_pop
);

  logic any_over;

  always_comb begin
    any_over = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      any_over = any_over | (src_bid[i*BID_W +: BID_W] > thr_q);
    end
  end

  AST_CIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!(bus_wr && bus_addr == 2'd0) && !ack_fall) |=> $stable(cir_q)); // R5
  AST_CIR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cap && !win_vld) |=> (cir_q == '0)); // R3
  AST_CIR_TYPE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cap && win_vld) |=> (cir_q[CIR_W-1 -: TYPE_W] != '0)); // R8
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    any_over |=> irq); // R9
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n_s)
    !any_over |=> !irq); // R9
  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(rx_pop)); // R10
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ack_fall |=> !ack_fall); // R6

endmodule

bind irq_capture_arb ica_checker #(
  .NUM_SRC (NUM_SRC),
  .NUM_RX  (NUM_RX),
  .BID_W   (BID_W),
  .TYPE_W  (TYPE_W),
  .CIR_W   (CIR_W)
) u_chk (
  .clk      (clk),
  .rst_n_s  (rst_n_s),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .ack_fall (ack_fall),
  .cap      (cap),
  .win_vld  (win_vld),
  .cir_q    (cir_q),
  .src_bid  (src_bid),
  .thr_q    (thr_q),
  .irq      (irq),
  .rx_pop   (rx_pop)
);

// File: tb/tb_irq_capture_arb.sv
module tb_irq_capture_arb;

  localparam int NSRC  = 11;
  localparam int NFIFO = 4;
  localparam int NRX   = 2;

  logic              clk;
  logic              rst_n;
  logic              iack_n;
  logic [NSRC*8-1:0] src_bid;
  logic [NFIFO*8-1:0] fifo_cnt;
  logic [NRX*8-1:0]  rx_data;
  logic [1:0]        bus_addr;
  logic              bus_wr;
  logic              bus_rd;
  logic [7:0]        bus_wdata;
  logic [15:0]       bus_rdata;
  logic [NRX-1:0]    rx_pop;
  logic              irq;

  int checks;
  int errors;

  irq_capture_arb dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .iack_n    (iack_n),
    .src_bid   (src_bid),
    .fifo_cnt  (fifo_cnt),
    .rx_data   (rx_data),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_pop    (rx_pop),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int mk(input int typ, input int ch, input int cnt);
    return (typ << 9) | (ch << 8) | cnt;
  endfunction

  // ---------------- reference model ----------------
  int   ackq[$];
  int   cir_m;
  int   thr_m;
  bit   irq_m;
  bit   model_on;

  function automatic int bid_of(input int i);
    return int'(src_bid[i*8 +: 8]);
  endfunction

  function automatic int rx_win();
    int top;
    top = 0;
    for (int i = 0; i < NRX; i++) if (bid_of(i) > top) top = bid_of(i);
    if (top == 0) return -1;
    for (int i = 0; i < NRX; i++) if (bid_of(i) == top) return i;
    return -1;
  endfunction

  function automatic int exp_rdata();
    int w;
    case (bus_addr)
      2'd0: return cir_m;
      2'd1: return thr_m;
      2'd2: begin
        w = rx_win();
        return (w < 0) ? 0 : int'(rx_data[w*8 +: 8]);
      end
      default: return 0;
    endcase
  endfunction

  function automatic int exp_pop();
    int w;
    w = rx_win();
    if (!(bus_rd && bus_addr == 2'd2) || w < 0) return 0;
    return 1 << w;
  endfunction

  always @(posedge clk) begin
    if (model_on) begin
      int  top;
      int  who;
      bit  cap;
      top = 0;
      who = -1;
      for (int i = 0; i < NSRC; i++) if (bid_of(i) > top) top = bid_of(i);
      for (int i = NSRC - 1; i >= 0; i--) if (bid_of(i) == top) who = i;
      if (top <= thr_m) who = -1;
      cap = (bus_wr && bus_addr == 2'd0) ||
            (ackq[ackq.size()-2] == 0 && ackq[ackq.size()-3] == 1);
      if (cap) begin
        if (who < 0) cir_m = 0;
        else cir_m = mk(who + 1, who % 2, (who < NFIFO) ? int'(fifo_cnt[who*8 +: 8]) : 0);
      end
      irq_m = (who >= 0);
      if (bus_wr && bus_addr == 2'd1) thr_m = int'(bus_wdata);
      ackq.push_back(int'(iack_n));
      if (ackq.size() > 8) void'(ackq.pop_front());
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk(irq === irq_m, "R9", int'(irq), int'(irq_m));
      chk(int'(bus_rdata) == exp_rdata(), "R2", int'(bus_rdata), exp_rdata());
      chk(int'(rx_pop) == exp_pop(), "R10", int'(rx_pop), exp_pop());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input int a, input int d);
    @(posedge clk); #1;
    bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic set_bid(input int i, input int v);
    src_bid[i*8 +: 8] = 8'(v);
  endtask

  task automatic expect_rd(input int a, input int exp, input string req);
    bus_addr = 2'(a);
    @(negedge clk);
    chk(int'(bus_rdata) == exp, req, int'(bus_rdata), exp);
    @(posedge clk); #1;
    bus_addr = 2'd0;
  endtask

  bit done;

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    model_on = 0; cir_m = 0; thr_m = 0; irq_m = 0;
    repeat (3) ackq.push_back(1);
    rst_n = 1'b0; iack_n = 1'b1;
    src_bid = '0; fifo_cnt = '0; rx_data = '0;
    bus_addr = 2'd0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    model_on = 1;
    cyc(4);

    // R1: reset state
    expect_rd(0, 0, "R1");
    expect_rd(1, 0, "R1");
    @(negedge clk); chk(irq === 1'b0, "R1", int'(irq), 0);
    cyc(1);

    // R11: threshold write and readback
    bus_write(1, 8'h10);
    expect_rd(1, 8'h10, "R11");

    // R4: tie between sources 2 and 5 goes to 2, FIFO count included (R7)
    fifo_cnt[2*8 +: 8] = 8'h07;
    set_bid(2, 8'h20); set_bid(5, 8'h20);
    bus_write(0, 0);
    expect_rd(0, mk(3, 0, 7), "R4");

    // R5: new higher bid without capture leaves the word alone
    set_bid(7, 8'h40);
    cyc(3);
    expect_rd(0, mk(3, 0, 7), "R5");

    // R7/R8: non-FIFO winner has zero count, channel 1, type 8
    bus_write(0, 0);
    expect_rd(0, mk(8, 1, 0), "R7");
    expect_rd(0, 16'h1100, "R8");

    // R3/R4: a bid equal to the threshold does not win, word loads 0
    set_bid(7, 8'h10); set_bid(5, 0); set_bid(2, 8'h05);
    bus_write(0, 0);
    expect_rd(0, 0, "R3");

    // R6: acknowledge falling edge captures on the third edge
    set_bid(3, 8'h30); fifo_cnt[3*8 +: 8] = 8'h55;
    iack_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); chk(int'(bus_rdata) == 0, "R6", int'(bus_rdata), 0);
    @(posedge clk);
    @(negedge clk); chk(int'(bus_rdata) == mk(4, 1, 8'h55), "R6", int'(bus_rdata), mk(4, 1, 8'h55));
    #1;
    set_bid(0, 8'h70);
    cyc(4);
    expect_rd(0, mk(4, 1, 8'h55), "R6");
    iack_n = 1'b1;
    cyc(5);
    expect_rd(0, mk(4, 1, 8'h55), "R6");

    // R12: threshold zero, single smallest bid gives non-zero word
    bus_write(1, 0);
    src_bid = '0;
    set_bid(10, 1);
    bus_write(0, 0);
    expect_rd(0, mk(11, 0, 0), "R12");

    // R10: global receive data follows highest receive bid
    src_bid = '0;
    rx_data = {8'hBB, 8'hAA};
    set_bid(0, 3); set_bid(1, 9);
    bus_rd = 1'b1; bus_addr = 2'd2;
    @(negedge clk);
    chk(int'(bus_rdata) == 8'hBB, "R10", int'(bus_rdata), 8'hBB);
    chk(int'(rx_pop) == 2, "R10", int'(rx_pop), 2);
    #1; set_bid(1, 3);
    @(negedge clk);
    chk(int'(bus_rdata) == 8'hAA, "R10", int'(bus_rdata), 8'hAA);
    chk(int'(rx_pop) == 1, "R10", int'(rx_pop), 1);
    #1; set_bid(0, 0); set_bid(1, 0);
    @(negedge clk);
    chk(int'(bus_rdata) == 0, "R10", int'(bus_rdata), 0);
    chk(int'(rx_pop) == 0, "R10", int'(rx_pop), 0);
    @(posedge clk); #1;
    bus_rd = 1'b0; bus_addr = 2'd0;

    // mixed random traffic, compared every clock by the model
    for (int n = 0; n < 600; n++) begin
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_rd = 1'b0;
      if ($urandom_range(0, 2) == 0) set_bid($urandom_range(0, NSRC - 1), $urandom_range(0, 40));
      if ($urandom_range(0, 7) == 0) fifo_cnt[$urandom_range(0, NFIFO - 1)*8 +: 8] = 8'($urandom);
      if ($urandom_range(0, 5) == 0) rx_data = 16'($urandom);
      if ($urandom_range(0, 5) == 0) iack_n = ~iack_n;
      bus_addr = 2'($urandom_range(0, 3));
      bus_rd = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 6) == 0) begin
        bus_wr = 1'b1;
        bus_wdata = 8'($urandom_range(0, 30));
      end
    end
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0;
    cyc(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule